// File: doc/BRIEF.md
# Display Data Channel Slave Port

This block is the serial side of a monitor's display data channel, as seen by a small on-chip processor. It has two operating states. In the stream state it sends bytes out on SDA with no addressing and no acknowledge, clocked by the host's SCL, and asks firmware for each next byte. In the addressed state it acts as an I2C-style slave. It detects START and STOP, compares the received 7-bit address with a programmed one, and acknowledges when enabled. It receives bytes into the data buffer or sends bytes taken from it. After every acknowledge it holds SCL low until firmware lets the bus go on.

Firmware uses three addresses. Address 0 is the data buffer. Address 1 reads as a status byte and writes as the address/acknowledge-enable byte; that write also releases a held SCL. Address 2 is a configuration byte that selects the state and gates the single level-sensitive interrupt. SCL and SDA are open-drain: the block only ever pulls a line low, through its output-enable pins.

The engine states are:
- STREAM: the stream state.
- IDLE: addressed state, no transfer.
- ADDR: shifting in the address byte.
- ACK: the slave drives an acknowledge.
- HOLD: SCL is held low until firmware releases it.
- RX: receiving a byte.
- TX: sending a byte.
- MACK: sampling the master's acknowledge.
- SKIP: ignoring the bus until the next START or STOP.

The transitions are:
- A START in any addressed state goes to ADDR. A STOP goes to IDLE.
- ADDR goes to ACK on a match with acknowledge enabled, and to SKIP otherwise.
- ACK goes to HOLD on the SCL fall.
- HOLD goes to TX or RX, according to the received R/W bit, on a control write.
- RX goes to ACK, or to SKIP when acknowledge is disabled.
- TX goes to MACK after eight bits.
- MACK goes to HOLD on an acknowledge and to SKIP on a NACK.
- A change of the state-select bit goes to STREAM or IDLE.

Top module: `ddc_slave`

## Requirements
- R1: After reset the data buffer reads FFh, the status reads 40h, the configuration reads 00h, irq is low, and both scl_oe and sda_oe are low.
- R2: Address 1 reads as status: bit7 is 1 in the addressed state, bit6 is the address-match flag, bit5 is the received R/W bit, bit4 is START seen, bit3 is STOP seen, and bits 2..0 are 0. It writes as the slave address in bits 7..1 and acknowledge-enable in bit 0, with reset value A0h. Address 2 holds the state select in bit7 (1 = addressed) and interrupt enable in bit0.
- R3: In the stream state each byte takes 9 SCL clocks. The first falling edge of a group loads the shift register from the data buffer. Data bits go out MSB first and change after a falling edge, so they are valid at the next rising edge. The ninth bit is released (reads 1).
- R4: In the stream state each load sets a buffer-empty condition, and a data-buffer write clears it. When the write falls in the same cycle as the load, the write wins: the condition stays clear, the loaded byte is the old buffer contents, and the new byte goes out in the next group.
- R5: In the addressed state, a START sets bit4 and clears bit3. A STOP sets bit3 and clears bit4.
- R6: The address is acknowledged only when the received 7 bits equal the programmed address and acknowledge is enabled. The match flag always records the comparison. On a mismatch or with acknowledge disabled, SDA and SCL are left alone until the next START.
- R7: In a write transfer, SDA is sampled on rising SCL. The whole byte goes into the data buffer at the end of the eighth bit, and the block acknowledges it when acknowledge is enabled.
- R8: In a read transfer, the data buffer is loaded into the shift register when the hold is released, and the byte is sent MSB first.
- R9: After every acknowledge, SCL is held low from the falling edge that ends the acknowledge bit. An interrupt cause is raised at the same moment. A write to address 1 releases SCL and clears that cause.
- R10: A NACK from the master after a read byte ends the transfer. SCL is not held, no interrupt is raised, and SDA stays released until the next START or STOP.
- R11: A STOP in the addressed state raises an interrupt cause, which stays set until address 1 is read.
- R12: irq is high when interrupt enable is set and any cause is pending. Causes stay pending while interrupts are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (clears STOP cause on address 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt to the processor |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
In the stream state, two things can happen in the same cycle: the shift register loads from the data buffer, and firmware writes the data buffer. The bench lowers SCL and counts the two synchronizer stages, so that its write strobe meets the edge on which the falling SCL takes effect. It then checks that irq stays low, that the group now starting carries the previous buffer byte, and that the group after it carries the newly written byte.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [3:0] {
        ST_STREAM,
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD,
        ST_RX,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } eng_state_t;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_CFG  = 2'd2;

    typedef struct packed {
        logic addr_done;
        logic addr_hit;
        logic rw;
        logic rx_done;
        logic ack_done;
        logic load;
    } eng_evt_t;

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] now_o,
    output logic [LINES-1:0] prev_o
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain  <= '1;
                    prev_q <= 1'b1;
                end else begin
                    chain  <= {chain[STAGES-2:0], pin_i[g]};
                    prev_q <= chain[STAGES-1];
                end
            end
            assign now_o[g]  = chain[STAGES-1];
            assign prev_o[g] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/ddc_engine.sv
module ddc_engine
    import ddc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_2b,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] tx_byte,
    input  logic [DW-2:0] own_addr,
    input  logic          ack_en,
    input  logic          release_i,
    output logic          sda_low,
    output logic          scl_hold,
    output logic [DW-1:0] rx_byte,
    output eng_evt_t      evt
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    eng_state_t    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [DW-1:0] sh, sh_n;
    logic          rw_q, rw_n, smp, smp_n, mode_q, mode_n;
    logic          hit;

    assign hit = (sh[DW-1:1] == own_addr);

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        sh_n   = sh;
        rw_n   = rw_q;
        smp_n  = smp;
        mode_n = mode_q;
        evt    = '0;
        if (mode_2b != mode_q) begin
            mode_n = mode_2b;
            st_n   = mode_2b ? ST_IDLE : ST_STREAM;
            cnt_n  = FULL;
            sh_n   = '1;
        end else if (mode_q && stop_det) begin
            st_n = ST_IDLE;
        end else if (mode_q && start_det) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && cnt != FULL) begin
                        sh_n  = {sh[DW-2:0], sda_s};
                        cnt_n = cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        if (st == ST_ADDR) begin
                            evt.addr_done = 1'b1;
                            evt.addr_hit  = hit;
                            evt.rw        = sh[0];
                            rw_n          = sh[0];
                            st_n          = (hit && ack_en) ? ST_ACK : ST_SKIP;
                        end else begin
                            evt.rx_done = 1'b1;
                            st_n        = ack_en ? ST_ACK : ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        st_n         = ST_HOLD;
                        evt.ack_done = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (release_i) begin
                        cnt_n = '0;
                        if (rw_q) begin
                            sh_n = tx_byte;
                            st_n = ST_TX;
                        end else begin
                            st_n = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        sh_n = {sh[DW-2:0], 1'b1};
                        if (cnt == LAST) begin
                            st_n  = ST_MACK;
                            cnt_n = FULL;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        smp_n = sda_s;
                    end else if (scl_fall) begin
                        if (!smp) begin
                            st_n         = ST_HOLD;
                            evt.ack_done = 1'b1;
                        end else begin
                            st_n = ST_SKIP;
                        end
                    end
                end
                ST_STREAM: begin
                    if (scl_fall) begin
                        if (cnt == FULL) begin
                            sh_n     = tx_byte;
                            cnt_n    = '0;
                            evt.load = 1'b1;
                        end else begin
                            sh_n  = {sh[DW-2:0], 1'b1};
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_STREAM;
            cnt    <= FULL;
            sh     <= '1;
            rw_q   <= 1'b0;
            smp    <= 1'b1;
            mode_q <= 1'b0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            sh     <= sh_n;
            rw_q   <= rw_n;
            smp    <= smp_n;
            mode_q <= mode_n;
        end
    end

    always_comb begin
        sda_low  = (st == ST_ACK)
                 | ((st == ST_TX) & ~sh[DW-1])
                 | ((st == ST_STREAM) & (cnt != FULL) & ~sh[DW-1]);
        scl_hold = (st == ST_HOLD);
        rx_byte  = sh;
    end

    AST_HOLD_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> mode_q); // R9
    AST_STREAM_NULL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STREAM && cnt == FULL) |-> !sda_low); // R3
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> (!sda_low && !scl_hold)); // R6
    AST_NACK_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK && scl_fall && smp && mode_2b == mode_q && !start_det && !stop_det)
            |=> (!scl_hold && !sda_low)); // R10

endmodule

// File: rtl/ddc_regs.sv
module ddc_regs
    import ddc_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] CTRL_RST = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          mode_2b,
    output logic [DW-2:0] own_addr,
    output logic          ack_en,
    output logic [DW-1:0] tx_byte,
    output logic          release_o,
    input  eng_evt_t      evt,
    input  logic [DW-1:0] rx_byte,
    input  logic          start_det,
    input  logic          stop_det
);

    logic [DW-1:0] data_buf, ctrl_q, status;
    logic cfg_mode, cfg_ien;
    logic f_match, f_rw, f_start, f_stop;
    logic tx_empty, ack_pend, stop_pend;
    logic wr_data, wr_ctrl, wr_cfg, rd_stat;

    assign wr_data   = bus_wr && (bus_addr == RA_DATA);
    assign wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
    assign wr_cfg    = bus_wr && (bus_addr == RA_CFG);
    assign rd_stat   = bus_rd && (bus_addr == RA_CTRL);
    assign mode_2b   = cfg_mode;
    assign own_addr  = ctrl_q[DW-1:1];
    assign ack_en    = ctrl_q[0];
    assign tx_byte   = data_buf;
    assign release_o = wr_ctrl;
    assign status    = {cfg_mode, f_match, f_rw, f_start, f_stop, {(DW-5){1'b0}}};
    assign irq       = cfg_ien & (tx_empty | ack_pend | stop_pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_buf  <= '1;
            ctrl_q    <= CTRL_RST;
            cfg_mode  <= 1'b0;
            cfg_ien   <= 1'b0;
            f_match   <= 1'b1;
            f_rw      <= 1'b0;
            f_start   <= 1'b0;
            f_stop    <= 1'b0;
            tx_empty  <= 1'b0;
            ack_pend  <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (wr_data)          data_buf <= bus_wdata;
            else if (evt.rx_done) data_buf <= rx_byte;
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_cfg) begin
                cfg_mode <= bus_wdata[DW-1];
                cfg_ien  <= bus_wdata[0];
            end
            if (evt.addr_done) begin
                f_match <= evt.addr_hit;
                f_rw    <= evt.rw;
            end
            if (cfg_mode && stop_det) begin
                f_stop  <= 1'b1;
                f_start <= 1'b0;
            end else if (cfg_mode && start_det) begin
                f_start <= 1'b1;
                f_stop  <= 1'b0;
            end
            if (wr_data)       tx_empty <= 1'b0;
            else if (evt.load) tx_empty <= 1'b1;
            if (evt.ack_done)  ack_pend <= 1'b1;
            else if (wr_ctrl)  ack_pend <= 1'b0;
            if (cfg_mode && stop_det) stop_pend <= 1'b1;
            else if (rd_stat)         stop_pend <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            RA_DATA: bus_rdata = data_buf;
            RA_CTRL: bus_rdata = status;
            RA_CFG:  bus_rdata = {cfg_mode, {(DW-2){1'b0}}, cfg_ien};
            default: bus_rdata = '0;
        endcase
    end

    AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && stop_det) |=> (f_stop && !f_start)); // R5
    AST_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && start_det && !stop_det) |=> f_start); // R5
    AST_RX_TO_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.rx_done && !wr_data) |=> (data_buf == $past(rx_byte))); // R7
    AST_EMPTY_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !tx_empty); // R4
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ack_done |=> ack_pend); // R9

endmodule

// File: rtl/ddc_slave.sv
module ddc_slave
    import ddc_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe
);

    logic [1:0]    pin_now, pin_prev;
    logic          scl_s, scl_p, sda_s, sda_p;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic          mode_2b, ack_en, release_w;
    logic [DW-2:0] own_addr;
    logic [DW-1:0] tx_byte, rx_byte;
    eng_evt_t      evt;

    ddc_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({scl_in, sda_in}),
        .now_o  (pin_now),
        .prev_o (pin_prev)
    );

    assign scl_s     = pin_now[1];
    assign sda_s     = pin_now[0];
    assign scl_p     = pin_prev[1];
    assign sda_p     = pin_prev[0];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    ddc_engine #(.DW(DW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_2b   (mode_2b),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_byte   (tx_byte),
        .own_addr  (own_addr),
        .ack_en    (ack_en),
        .release_i (release_w),
        .sda_low   (sda_oe),
        .scl_hold  (scl_oe),
        .rx_byte   (rx_byte),
        .evt       (evt)
    );

    ddc_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .mode_2b   (mode_2b),
        .own_addr  (own_addr),
        .ack_en    (ack_en),
        .tx_byte   (tx_byte),
        .release_o (release_w),
        .evt       (evt),
        .rx_byte   (rx_byte),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

endmodule

// File: tb/ddc_slave_bench.sv
module ddc_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_line, sda_line;
    int         total = 0, fails = 0;
    bit         done = 1'b0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    ddc_slave u_ddc_slave (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] exp_status(input bit m, input bit hit, input bit rw,
                                              input bit st, input bit sp);
        return {m, hit, rw, st, sp, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic s1_clock(output logic s);
        scl_m = 1'b0; half();
        scl_m = 1'b1; half();
        s = sda_line;
    endtask

    task automatic s1_rest(output logic [7:0] b, output logic nul, input logic first);
        logic s;
        b[7] = first;
        for (int i = 6; i >= 0; i--) begin
            s1_clock(s);
            b[i] = s;
        end
        s1_clock(nul);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; half();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
        half();
        scl_m = 1'b0; half();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; half();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
        half();
        b = sda_line;
        scl_m = 1'b0; half();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(s);
            b[i] = s;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, b, prev_b, nb, bc;
        logic       s, nul;
        int         seed;
        seed = $urandom(32'h5EED_0D0C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, r); chk("R1 data reset", r, 8'hFF);
        peek(2'd1, r); chk("R1 status reset", r, 8'h40);
        peek(2'd2, r); chk("R1 cfg reset", r, 8'h00);
        chk("R1 pins/irq", {5'd0, irq, scl_oe, sda_oe}, 8'h00);

        // R3/R4 stream state
        bwr(2'd2, 8'h01);
        peek(2'd2, r); chk("R2 cfg readback", r, 8'h01);
        prev_b = 8'($urandom);
        bwr(2'd0, prev_b);
        for (int g = 0; g < 4; g++) begin
            s1_clock(s);
            chk("R4 empty irq after load", {7'd0, irq}, 8'h01);
            nb = 8'($urandom);
            bwr(2'd0, nb);
            chk("R4 write clears empty", {7'd0, irq}, 8'h00);
            s1_rest(b, nul, s);
            chk("R3 stream byte", b, prev_b);
            chk("R3 null bit released", {7'd0, nul}, 8'h01);
            prev_b = nb;
        end
        // R4 collision: data write on the load edge
        bc = 8'($urandom);
        @(negedge clk); scl_m = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 2'd0; bus_wdata = bc; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R4 same-cycle write wins", {7'd0, irq}, 8'h00);
        repeat (6) @(negedge clk);
        scl_m = 1'b1; half(); s = sda_line;
        s1_rest(b, nul, s);
        chk("R4 collision sends old byte", b, prev_b);
        s1_clock(s);
        bwr(2'd0, 8'h00);
        s1_rest(b, nul, s);
        chk("R4 next group sends new byte", b, bc);

        // addressed state
        bwr(2'd2, 8'h81);
        bwr(2'd1, 8'hA1);
        peek(2'd1, r); chk("R2 status addressed", r, exp_status(1, 1, 0, 0, 0));

        // write transfer
        i2c_start();
        peek(2'd1, r); chk("R5 start flag", r, exp_status(1, 1, 0, 1, 0));
        send_byte(8'hA0);
        recv_bit(s); chk("R6 address acked", {7'd0, s}, 8'h00);
        chk("R9 hold and irq after ack", {6'd0, scl_oe, irq}, 8'h03);
        bwr(2'd1, 8'hA1);
        chk("R9 release clears", {6'd0, scl_oe, irq}, 8'h00);
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom);
            send_byte(b);
            recv_bit(s); chk("R7 data acked", {7'd0, s}, 8'h00);
            chk("R9 hold after data ack", {6'd0, scl_oe, irq}, 8'h03);
            peek(2'd0, r); chk("R7 byte latched", r, b);
            bwr(2'd1, 8'hA1);
        end
        i2c_stop();
        peek(2'd1, r); chk("R5 stop flag", r, exp_status(1, 1, 0, 0, 1));
        chk("R11 stop irq", {7'd0, irq}, 8'h01);
        brd(2'd1, r);
        chk("R11 status read clears", {7'd0, irq}, 8'h00);

        // read transfer
        i2c_start();
        send_byte(8'hA1);
        recv_bit(s); chk("R6 read address acked", {7'd0, s}, 8'h00);
        peek(2'd1, r); chk("R2 rw flag", r, exp_status(1, 1, 1, 1, 0));
        b = 8'($urandom);
        bwr(2'd0, b); bwr(2'd1, 8'hA1);
        recv_byte(r); chk("R8 read byte 0", r, b);
        send_bit(1'b0);
        chk("R9 hold after master ack", {6'd0, scl_oe, irq}, 8'h03);
        b = 8'($urandom);
        bwr(2'd0, b); bwr(2'd1, 8'hA1);
        recv_byte(r); chk("R8 read byte 1", r, b);
        send_bit(1'b1);
        chk("R10 no hold after nack", {5'd0, scl_oe, sda_oe, irq}, 8'h00);
        recv_byte(r); chk("R10 sda released", r, 8'hFF);
        i2c_stop();
        brd(2'd1, r);

        // address mismatch
        nb = 8'($urandom % 128);
        if (nb == 8'h50) nb = 8'h51;
        i2c_start();
        send_byte({nb[6:0], 1'b0});
        recv_bit(s); chk("R6 mismatch nack", {7'd0, s}, 8'h01);
        chk("R6 mismatch no hold", {6'd0, scl_oe, irq}, 8'h00);
        peek(2'd1, r); chk("R6 match flag clear", r, exp_status(1, 0, 0, 1, 0));
        send_byte(8'h00);
        recv_bit(s); chk("R6 ignored byte", {7'd0, s}, 8'h01);
        i2c_stop();
        brd(2'd1, r);

        // acknowledge disabled
        bwr(2'd1, 8'hA0);
        i2c_start();
        send_byte(8'hA0);
        recv_bit(s); chk("R6 ack disabled nack", {7'd0, s}, 8'h01);
        peek(2'd1, r); chk("R6 match with ack off", r, exp_status(1, 1, 0, 1, 0));
        i2c_stop();
        brd(2'd1, r);
        bwr(2'd1, 8'hA1);

        // R12 enable gating
        bwr(2'd2, 8'h80);
        i2c_start();
        i2c_stop();
        chk("R12 gated irq", {7'd0, irq}, 8'h00);
        peek(2'd1, r); chk("R12 stop flag while gated", r, exp_status(1, 1, 0, 0, 1));
        bwr(2'd2, 8'h81);
        chk("R12 pending cause shows", {7'd0, irq}, 8'h01);
        brd(2'd1, r);
        chk("R12 cleared", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule